// File: doc/BRIEF.md
# Register Scoreboard for In-Order Issue

This block guards the issue stage of a pipeline that sends instructions to its functional units in program order, while those units finish after different latencies and so hand back results out of order. It keeps one pending flag per architectural register and a small register file. Each cycle it looks at the offered instruction (destination, two sources, unit select). It either dispatches the instruction to the selected unit, with both operand values, or holds it back with a stall.

Every register other than register 0 is a two-state machine with states SLOT_CLEAN and SLOT_PENDING. The claim transition (SLOT_CLEAN to SLOT_PENDING) is taken when a dispatched instruction names the register as its destination. The retire transition (SLOT_PENDING to SLOT_CLEAN) is taken when a completion port returns a result for it, and that result is written into the register. If a claim and a retire land in the same cycle, the claim wins.

The issue decision is a combinational verdict with five states. VD_IDLE means no instruction is offered. VD_RAW means a source is pending. VD_WAW means the destination is pending. VD_BUSY means the selected unit cannot accept. VD_GO means dispatch. These checks are tested in that priority order. Completions only take effect at the next clock edge, so a result arriving in the same cycle as an issue check is not bypassed to it.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every register reads zero and none is pending, so an instruction naming any registers issues without stall when its unit is ready.
- R2: A valid instruction stalls while the pending flag of either source register is set.
- R3: A valid instruction stalls while the pending flag of its destination register is set.
- R4: When no stall applies, the instruction dispatches in the same cycle. `disp_opa` and `disp_opb` always show the current contents of the registers named by `iss_src_a` and `iss_src_b`. A nonzero destination reads as pending from the next cycle on.
- R5: A completion on port p (`cpl_valid[p]`, register `cpl_dst[p*AW +: AW]`, value `cpl_data[p*DW +: DW]`) writes the value into the register and clears its pending flag. Both are visible from the next cycle.
- R6: Bit u of `disp_valid` is high exactly when an instruction dispatches with unit select u. At most one bit is high, and all bits are low when the instruction stalls or none is offered.
- R7: A valid instruction stalls when `fu_ready` is low for its selected unit, or when the unit select names no existing unit (value NU or above).
- R8: A source register whose completion arrives in the same cycle as the issue check still stalls the instruction in that cycle. The instruction issues in the following cycle with the newly written value.
- R9: Register 0 always reads zero and never becomes pending. Dispatching with destination 0 does not block later readers, and completions naming register 0 are discarded.
- R10: Several completion ports may write different registers in the same cycle, and every one of those writes takes effect. Two ports naming the same register in one cycle is a usage error, flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_dst | input | AW | Destination register of the offered instruction |
| iss_src_a | input | AW | First source register |
| iss_src_b | input | AW | Second source register |
| iss_unit | input | UW | Functional unit select |
| fu_ready | input | NU | Per-unit ability to accept an instruction this cycle |
| iss_stall | output | 1 | Offered instruction is held back this cycle |
| disp_valid | output | NU | One-hot dispatch strobe to the selected unit |
| disp_dst | output | AW | Destination register sent with the dispatch |
| disp_opa | output | DW | Current contents of the first source register |
| disp_opb | output | DW | Current contents of the second source register |
| cpl_valid | input | NU | Per-port completion strobe |
| cpl_dst | input | NU*AW | Per-port completing register, port p in bits p*AW +: AW |
| cpl_data | input | NU*DW | Per-port result value, port p in bits p*DW +: DW |

## Verification
A register stuck in SLOT_PENDING shows up as a stall that never lifts for any reader or writer of that register, and it appears in the first cycle such an instruction is offered. A register that drops back to SLOT_CLEAN too early shows up as dispatched operands that hold the old value instead of the result still in flight, again in the first cycle a reader is offered. A wrong completion mux or a write that does not land is seen one cycle after the completion, as a wrong value on `disp_opa` or `disp_opb` for any instruction that names that register. A variable-latency stream with a bench-side model of flags and contents compares these effects cycle by cycle.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;

    typedef enum logic {
        SLOT_CLEAN   = 1'b0,
        SLOT_PENDING = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        VD_IDLE = 3'd0,
        VD_GO   = 3'd1,
        VD_RAW  = 3'd2,
        VD_WAW  = 3'd3,
        VD_BUSY = 3'd4
    } iss_verdict_e;

endpackage

// File: rtl/sb_reg_slot.sv
`timescale 1ns/1ps
module sb_reg_slot
    import sb_pkg::*;
#(
    parameter int IDX = 1,
    parameter int AW  = 3,
    parameter int DW  = 16,
    parameter int NP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_fire_i,
    input  logic [AW-1:0]    iss_dst_i,
    input  logic [NP-1:0]    cpl_valid_i,
    input  logic [NP*AW-1:0] cpl_dst_i,
    input  logic [NP*DW-1:0] cpl_data_i,
    output logic             pend_o,
    output logic [DW-1:0]    data_o
);

    localparam logic [AW-1:0] MY_ADDR = AW'(IDX);

    slot_state_e     state_q, state_d;
    logic [NP-1:0]   hit;
    logic [DW-1:0]   wdata;
    logic            claim;
    logic            retire;
    logic [DW-1:0]   data_q;

    // Completion port match and result select
    always_comb begin
        hit   = '0;
        wdata = '0;
        for (int p = 0; p < NP; p++) begin
            if (cpl_valid_i[p] && (cpl_dst_i[p*AW +: AW] == MY_ADDR)) begin
                hit[p] = 1'b1;
                wdata  = wdata | cpl_data_i[p*DW +: DW];
            end
        end
    end

    assign claim  = iss_fire_i && (iss_dst_i == MY_ADDR);
    assign retire = |hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_CLEAN;
        else        state_q <= state_d;
    end

    // Next state: a claim outranks a retire in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_CLEAN: begin
                if (claim) state_d = SLOT_PENDING;
            end
            SLOT_PENDING: begin
                if (claim)       state_d = SLOT_PENDING;
                else if (retire) state_d = SLOT_CLEAN;
            end
        endcase
    end

    // Register contents
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (retire) data_q <= wdata;
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == SLOT_PENDING);
        data_o = data_q;
    end

    p_single_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) <= 1)
        else $error("two completion ports target register %0d", IDX);

    p_claim_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> pend_o);

    p_retire_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !claim) |=> (!pend_o && (data_o == $past(wdata))));

    p_quiet_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !claim) |=> ($stable(data_o) && $stable(pend_o)));

endmodule

// File: rtl/sb_hazard.sv
`timescale 1ns/1ps
module sb_hazard
    import sb_pkg::*;
#(
    parameter int AW = 3,
    parameter int NU = 3,
    parameter int UW = 2,
    localparam int NREG = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [AW-1:0]   src_a_i,
    input  logic [AW-1:0]   src_b_i,
    input  logic [AW-1:0]   dst_i,
    input  logic [UW-1:0]   unit_i,
    input  logic [NREG-1:0] pend_i,
    input  logic [NU-1:0]   fu_ready_i,
    output logic            stall_o,
    output logic            fire_o,
    output logic [NU-1:0]   disp_valid_o
);

    iss_verdict_e verdict;
    logic         raw_hit;
    logic         waw_hit;
    logic         unit_ready;

    // Structural check: unselectable unit numbers are never ready
    always_comb begin
        unit_ready = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (unit_i == UW'(u)) unit_ready = fu_ready_i[u];
        end
    end

    assign raw_hit = pend_i[src_a_i] || pend_i[src_b_i];
    assign waw_hit = pend_i[dst_i];

    // Verdict, checked in priority order
    always_comb begin
        if (!valid_i)        verdict = VD_IDLE;
        else if (raw_hit)    verdict = VD_RAW;
        else if (waw_hit)    verdict = VD_WAW;
        else if (!unit_ready) verdict = VD_BUSY;
        else                 verdict = VD_GO;
    end

    // Outputs from the verdict
    always_comb begin
        stall_o = 1'b0;
        fire_o  = 1'b0;
        unique case (verdict)
            VD_IDLE: ;
            VD_GO:   fire_o  = 1'b1;
            VD_RAW,
            VD_WAW,
            VD_BUSY: stall_o = 1'b1;
            default: ;
        endcase
    end

    for (genvar u = 0; u < NU; u++) begin : g_disp
        assign disp_valid_o[u] = fire_o && (unit_i == UW'(u));

        p_unit_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
            disp_valid_o[u] |-> fu_ready_i[u]);
    end

    p_raw_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (pend_i[src_a_i] || pend_i[src_b_i])) |-> (stall_o && !fire_o));

    p_waw_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pend_i[dst_i]) |-> (stall_o && !fire_o));

    p_one_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> ($countones(disp_valid_o) == 1));

    p_no_stray_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_o |-> !$onehot0(disp_valid_o) == 1'b0 && (disp_valid_o == '0));

endmodule

// File: rtl/reg_scoreboard.sv
`timescale 1ns/1ps
module reg_scoreboard #(
    parameter int AW = 3,
    parameter int DW = 16,
    parameter int NU = 3,
    parameter int UW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [AW-1:0]    iss_dst,
    input  logic [AW-1:0]    iss_src_a,
    input  logic [AW-1:0]    iss_src_b,
    input  logic [UW-1:0]    iss_unit,
    input  logic [NU-1:0]    fu_ready,
    output logic             iss_stall,
    output logic [NU-1:0]    disp_valid,
    output logic [AW-1:0]    disp_dst,
    output logic [DW-1:0]    disp_opa,
    output logic [DW-1:0]    disp_opb,
    input  logic [NU-1:0]    cpl_valid,
    input  logic [NU*AW-1:0] cpl_dst,
    input  logic [NU*DW-1:0] cpl_data
);

    localparam int NREG = 1 << AW;

    logic [NREG-1:0] pend;
    logic [DW-1:0]   rf [NREG];
    logic            fire;

    sb_hazard #(
        .AW (AW),
        .NU (NU),
        .UW (UW)
    ) u_hazard (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (iss_valid),
        .src_a_i      (iss_src_a),
        .src_b_i      (iss_src_b),
        .dst_i        (iss_dst),
        .unit_i       (iss_unit),
        .pend_i       (pend),
        .fu_ready_i   (fu_ready),
        .stall_o      (iss_stall),
        .fire_o       (fire),
        .disp_valid_o (disp_valid)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign pend[i] = 1'b0;
            assign rf[i]   = '0;
        end else begin : g_slot
            sb_reg_slot #(
                .IDX (i),
                .AW  (AW),
                .DW  (DW),
                .NP  (NU)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .iss_fire_i  (fire),
                .iss_dst_i   (iss_dst),
                .cpl_valid_i (cpl_valid),
                .cpl_dst_i   (cpl_dst),
                .cpl_data_i  (cpl_data),
                .pend_o      (pend[i]),
                .data_o      (rf[i])
            );
        end
    end

    assign disp_dst = iss_dst;
    assign disp_opa = rf[iss_src_a];
    assign disp_opb = rf[iss_src_b];

    p_stall_xor_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_stall && (disp_valid != '0)));

    p_stall_needs_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> iss_valid);

endmodule

// File: tb/reg_scoreboard_bench.sv
`timescale 1ns/1ps
module reg_scoreboard_bench;

    localparam int AW   = 3;
    localparam int DW   = 16;
    localparam int NU   = 3;
    localparam int UW   = 2;
    localparam int NREG = 1 << AW;
    localparam int NINS = 120;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [AW-1:0]    iss_dst = '0;
    logic [AW-1:0]    iss_src_a = '0;
    logic [AW-1:0]    iss_src_b = '0;
    logic [UW-1:0]    iss_unit = '0;
    logic [NU-1:0]    fu_ready = '0;
    logic             iss_stall;
    logic [NU-1:0]    disp_valid;
    logic [AW-1:0]    disp_dst;
    logic [DW-1:0]    disp_opa;
    logic [DW-1:0]    disp_opb;
    logic [NU-1:0]    cpl_valid = '0;
    logic [NU*AW-1:0] cpl_dst = '0;
    logic [NU*DW-1:0] cpl_data = '0;

    int nchk = 0;
    int nfail = 0;

    logic [DW-1:0] m_reg  [NREG];
    logic          m_pend [NREG];
    logic          u_busy [NU];
    int            u_done [NU];
    int            u_dst  [NU];
    logic [DW-1:0] u_val  [NU];

    reg_scoreboard #(.AW(AW), .DW(DW), .NU(NU), .UW(UW)) u_reg_scoreboard (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_dst    (iss_dst),
        .iss_src_a  (iss_src_a),
        .iss_src_b  (iss_src_b),
        .iss_unit   (iss_unit),
        .fu_ready   (fu_ready),
        .iss_stall  (iss_stall),
        .disp_valid (disp_valid),
        .disp_dst   (disp_dst),
        .disp_opa   (disp_opa),
        .disp_opb   (disp_opb),
        .cpl_valid  (cpl_valid),
        .cpl_dst    (cpl_dst),
        .cpl_data   (cpl_data)
    );

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] dval(int d);
        return DW'(32'h1000 + d * 32'h0111);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_iss(bit v, int d, int a, int b, int u);
        iss_valid = v;
        iss_dst   = AW'(d);
        iss_src_a = AW'(a);
        iss_src_b = AW'(b);
        iss_unit  = UW'(u);
    endtask

    task automatic clr_cpl();
        cpl_valid = '0;
        cpl_dst   = '0;
        cpl_data  = '0;
    endtask

    task automatic put_cpl(int p, int d, logic [DW-1:0] v);
        cpl_valid[p]          = 1'b1;
        cpl_dst[p*AW +: AW]   = AW'(d);
        cpl_data[p*DW +: DW]  = v;
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int c;
        int k;
        int fired;
        bit anybusy;

        // Reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        set_iss(0, 0, 0, 0, 0);
        #1;
        chk("R1", "stall idle", int'(iss_stall), 0);
        chk("R1", "disp idle", int'(disp_valid), 0);
        for (int r = 0; r < NREG; r++) begin
            iss_src_a = AW'(r);
            iss_src_b = AW'(r);
            #1;
            chk("R1", "reset contents", int'(disp_opa), 0);
        end

        // Claim registers 1..7, each from a clean state
        fu_ready = '1;
        for (int d = 1; d < NREG; d++) begin
            @(negedge clk);
            set_iss(1, d, d, 0, d % NU);
            #1;
            chk("R1", "clean issue stall", int'(iss_stall), 0);
            chk("R6", "dispatch strobe", int'(disp_valid), 1 << (d % NU));
            chk("R4", "operand a", int'(disp_opa), 0);
            chk("R4", "dispatch dst", int'(disp_dst), d);
        end

        // Hazard sweep over every pending register
        for (int d = 1; d < NREG; d++) begin
            @(negedge clk);
            set_iss(1, 0, d, 0, 0);
            #1;
            chk("R2", "raw via src a", int'(iss_stall), 1);
            chk("R6", "no strobe when stalled", int'(disp_valid), 0);
            @(negedge clk);
            set_iss(1, 0, 0, d, 1);
            #1;
            chk("R2", "raw via src b", int'(iss_stall), 1);
            @(negedge clk);
            set_iss(1, d, 0, 0, 2);
            #1;
            chk("R3", "waw on dst", int'(iss_stall), 1);
        end

        // Structural checks per unit, destination 0
        for (int u = 0; u < NU; u++) begin
            @(negedge clk);
            fu_ready = NU'(1 << u);
            set_iss(1, 0, 0, 0, u);
            #1;
            chk("R7", "ready unit fires", int'(iss_stall), 0);
            chk("R6", "strobe on unit", int'(disp_valid), 1 << u);
            @(negedge clk);
            fu_ready = ~NU'(1 << u);
            #1;
            chk("R7", "busy unit stalls", int'(iss_stall), 1);
        end
        @(negedge clk);
        fu_ready = '1;
        set_iss(1, 0, 0, 0, NU);
        #1;
        chk("R7", "missing unit stalls", int'(iss_stall), 1);
        chk("R7", "missing unit strobe", int'(disp_valid), 0);

        // Register 0 never pending after dst-0 dispatches
        @(negedge clk);
        set_iss(1, 0, 0, 0, 0);
        #1;
        chk("R9", "reg0 reader stall", int'(iss_stall), 0);
        chk("R9", "reg0 value", int'(disp_opa), 0);

        // Completion groups on several ports at once
        @(negedge clk);
        clr_cpl();
        put_cpl(0, 1, dval(1));
        put_cpl(1, 2, dval(2));
        put_cpl(2, 3, dval(3));
        set_iss(1, 0, 1, 0, 0);
        #1;
        chk("R8", "same-cycle completion still stalls", int'(iss_stall), 1);
        @(negedge clk);
        clr_cpl();
        put_cpl(2, 4, dval(4));
        put_cpl(0, 5, dval(5));
        put_cpl(1, 6, dval(6));
        set_iss(1, 0, 1, 2, 0);
        #1;
        chk("R8", "issues next cycle", int'(iss_stall), 0);
        chk("R8", "new value a", int'(disp_opa), int'(dval(1)));
        chk("R10", "parallel write b", int'(disp_opb), int'(dval(2)));
        @(negedge clk);
        clr_cpl();
        put_cpl(1, 7, dval(7));
        put_cpl(0, 0, 16'hBEEF);
        set_iss(0, 0, 0, 0, 0);
        @(negedge clk);
        clr_cpl();
        for (int r = 1; r < NREG; r++) begin
            set_iss(1, 0, r, r, r % NU);
            #1;
            chk("R5", "readback a", int'(disp_opa), int'(dval(r)));
            chk("R10", "readback b", int'(disp_opb), int'(dval(r)));
            chk("R5", "flag cleared", int'(iss_stall), 0);
            @(negedge clk);
        end
        set_iss(0, 0, 0, 0, 0);
        #1;
        chk("R9", "write to reg0 dropped", int'(disp_opa), 0);

        // Variable-latency stream against a bench model
        for (int r = 0; r < NREG; r++) begin
            m_reg[r]  = (r == 0) ? '0 : dval(r);
            m_pend[r] = 1'b0;
        end
        for (int u = 0; u < NU; u++) begin
            u_busy[u] = 1'b0;
            u_done[u] = 0;
            u_dst[u]  = 0;
            u_val[u]  = '0;
        end
        k = 0;
        fired = 0;
        c = 0;
        anybusy = 1'b0;
        while ((fired < NINS || anybusy) && c < 20000) begin
            bit v;
            int a;
            int b;
            int d;
            int u;
            bit es;
            bit ef;
            @(negedge clk);
            clr_cpl();
            for (int p = 0; p < NU; p++) begin
                if (u_busy[p] && u_done[p] == c) put_cpl(p, u_dst[p], u_val[p]);
                fu_ready[p] = !u_busy[p];
            end
            a = (k * 5 + 1) % NREG;
            b = (k * 3 + 2) % NREG;
            d = (k * 7 + 3) % (NREG - 1) + 1;
            u = (k * 11 + k / 4) % NU;
            v = (fired < NINS) && ((k % 9) != 4);
            set_iss(v, d, a, b, u);
            es = v && (m_pend[a] || m_pend[b] || m_pend[d] || u_busy[u]);
            ef = v && !es;
            #1;
            chk("R2/R3/R7", "stream stall", int'(iss_stall), int'(es));
            chk("R6", "stream strobe", int'(disp_valid), ef ? (1 << u) : 0);
            if (ef) begin
                chk("R4", "stream operand a", int'(disp_opa), int'(m_reg[a]));
                chk("R4", "stream operand b", int'(disp_opb), int'(m_reg[b]));
            end
            for (int p = 0; p < NU; p++) begin
                if (u_busy[p] && u_done[p] == c) begin
                    m_reg[u_dst[p]]  = u_val[p];
                    m_pend[u_dst[p]] = 1'b0;
                    u_busy[p]        = 1'b0;
                end
            end
            if (ef) begin
                m_pend[d] = 1'b1;
                u_busy[u] = 1'b1;
                u_done[u] = c + 1 + ((k * 3 + u) % 5);
                u_dst[u]  = d;
                u_val[u]  = DW'(m_reg[a] + m_reg[b] + DW'(k) + DW'(u * 257));
                fired++;
                k++;
            end else if (!v) begin
                k++;
            end
            anybusy = 1'b0;
            for (int p = 0; p < NU; p++) anybusy |= u_busy[p];
            c++;
        end
        @(negedge clk);
        clr_cpl();
        set_iss(0, 0, 0, 0, 0);
        for (int r = 0; r < NREG; r++) begin
            iss_src_a = AW'(r);
            iss_src_b = AW'((r + 1) % NREG);
            #1;
            chk("R5", "final contents a", int'(disp_opa), int'(m_reg[r]));
            chk("R5", "final contents b", int'(disp_opb), int'(m_reg[(r + 1) % NREG]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule